// File: doc/BRIEF.md
# Multi-Pin TDM Audio Serial Port

This block is a synchronous audio serial port with eight serial data lines that share two timing zones, one for transmit and one for receive. Each zone divides the master clock into a bit clock, counts bits and slots, and produces a frame-sync pulse. A frame holds a set number of time slots, and each slot holds a set number of bits. A static per-pin direction input attaches each data line to one of the two zones. Every line on the same zone shifts in step with that zone's bit clock.

Sample words move through per-pin ready/valid interfaces. A transmit line launches the upper bits of its word, most significant bit first, on the falling bit-clock edge. A receive line samples on the rising edge and presents a left-justified word. A per-zone slot mask selects which slots carry data. Lost data on either side sets a sticky flag. All configuration comes in on static inputs, which are changed only while reset is held.

Top module: `tdm_serial_port`

## Requirements
- R1: The bit clock of a zone has a period of 2*(div+1) master-clock cycles, with equal high and low halves (div 0..127 gives ratios 2..256).
- R2: Width code c from 0 to 6 selects a slot of 8+4*c bits. Code 7 is not a legal width and gives 32 bits.
- R3: Slot field n gives n+1 slots per frame, and n=0 is raised to 2 slots. The frame sync therefore repeats every slots*width*ratio master cycles.
- R4: With the wide-sync input at 0, the frame sync is high for one bit period. With it at 1, the frame sync is high for one slot.
- R5: With the delay input at 0, the frame sync rises at the first bit of slot 0. With it at 1, the frame sync rises one bit period earlier.
- R6: A pin whose direction bit is 1 transmits on the transmit zone. A pin whose direction bit is 0 receives on the receive zone and never drives its enable. A transmitted slot carries bits [31:32-W] of the word, most significant bit first.
- R7: A received word carries the W slot bits in [31:32-W], with zeros in the bits below.
- R8: Mask bit s selects slot s. In a slot whose mask bit is 0, transmit enables are low, no word is consumed and no word is produced.
- R9: A transmit pin with no word ready at the start of an active slot sends zeros for that slot and sets its sticky underrun flag.
- R10: If a receive word is completed while the previous word is still untaken, the new word replaces it and the sticky overrun flag is set.
- R11: Receive valid stays high until the consumer takes the word with ready.
- R12: Frame sync and pin enables change only in the master cycle in which the transmit bit clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_is_tx | input | NPINS | Per-pin zone select, 1 = transmit |
| tx_div | input | DIVW | Transmit bit-clock divide field |
| tx_slots_m1 | input | SLOTW | Transmit slots per frame minus one |
| tx_wcode | input | 3 | Transmit slot width code |
| tx_fs_wide | input | 1 | Transmit frame sync lasts one slot |
| tx_fs_delay | input | 1 | Transmit one-bit data delay |
| tx_mask | input | 2**SLOTW | Transmit active-slot mask |
| rx_div | input | DIVW | Receive bit-clock divide field |
| rx_slots_m1 | input | SLOTW | Receive slots per frame minus one |
| rx_wcode | input | 3 | Receive slot width code |
| rx_fs_wide | input | 1 | Receive frame sync lasts one slot |
| rx_fs_delay | input | 1 | Receive one-bit data delay |
| rx_mask | input | 2**SLOTW | Receive active-slot mask |
| tx_bclk | output | 1 | Transmit zone bit clock |
| tx_fs | output | 1 | Transmit zone frame sync |
| rx_bclk | output | 1 | Receive zone bit clock |
| rx_fs | output | 1 | Receive zone frame sync |
| sd_in | input | NPINS | Serial data in |
| sd_out | output | NPINS | Serial data out |
| sd_oe | output | NPINS | Serial data output enable |
| tx_data | input | NPINS*32 | Per-pin transmit words |
| tx_valid | input | NPINS | Transmit word valid |
| tx_ready | output | NPINS | Transmit holding register free |
| rx_data | output | NPINS*32 | Per-pin received words |
| rx_valid | output | NPINS | Received word valid |
| rx_ready | input | NPINS | Received word taken |
| underrun | output | NPINS | Sticky transmit underrun flags |
| overrun | output | NPINS | Sticky receive overrun flags |

## Verification
The bit clock, frame sync and enables are registered in the master cycle where a bit starts. The bench therefore measures rise-to-rise periods, high times and the sync-to-enable offset as exact master-cycle counts, sampled at the falling edge of the master clock. Transmit pins are looped back to receive pins running an identical zone. A received word becomes valid one cycle after the rising-edge sample of its last bit, so the bench takes each word at the falling edge where valid and ready are both high. It compares that word with the sequence it fed, masked to the slot width. Underrun and overrun are judged only after two whole frames have passed, so every slot boundary that could raise them has occurred.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
  localparam int WMAX  = 32;
  localparam int WBITS = 6;

  typedef struct packed {
    logic             launch;
    logic             slot_start;
    logic             act_next;
    logic             sample;
    logic             act_cur;
    logic             last_bit;
    logic [WBITS-1:0] width;
  } zone_evt_t;

  function automatic logic [WBITS-1:0] slot_bits(input logic [2:0] code);
    if (code == 3'd7) return WBITS'(WMAX);
    return WBITS'(8 + 4 * int'(code));
  endfunction
endpackage

// File: rtl/tdm_zone_timer.sv
`timescale 1ns/1ps
module tdm_zone_timer #(
  parameter int DIVW  = 7,
  parameter int SLOTW = 5,
  parameter int NSLOT = 1 << SLOTW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIVW-1:0]   div,
  input  logic [SLOTW-1:0]  slots_m1,
  input  logic [2:0]        wcode,
  input  logic              fs_wide,
  input  logic              fs_delay,
  input  logic [NSLOT-1:0]  mask,
  output logic              bclk,
  output logic              fs,
  output tdm_pkg::zone_evt_t evt
);
  import tdm_pkg::*;

  logic [WBITS-1:0] w, bit_q, nbit;
  logic [SLOTW-1:0] last_slot, slot_q, nslot;
  logic [DIVW-1:0]  hc_q;
  logic phase_q, run_q, wrap, launch, bit_end, fs_nx, fs_pre;

  function automatic logic fs_at(input logic [SLOTW-1:0] s, lst,
                                 input logic [WBITS-1:0] b, wd,
                                 input logic wide, dly);
    logic lead;
    lead = (s == lst) && (b == wd - 1'b1);
    if (!wide) return dly ? lead : (s == '0 && b == '0);
    return dly ? (lead || (s == '0 && b != wd - 1'b1)) : (s == '0);
  endfunction

  assign w         = slot_bits(wcode);
  assign last_slot = (slots_m1 == '0) ? SLOTW'(1) : slots_m1;
  assign wrap      = (hc_q == div);
  assign launch    = wrap & phase_q;
  assign bit_end   = (bit_q == w - 1'b1);

  always_comb begin
    nbit  = bit_end ? '0 : bit_q + 1'b1;
    nslot = slot_q;
    if (bit_end) nslot = (slot_q == last_slot) ? '0 : slot_q + 1'b1;
  end

  assign fs_nx  = fs_at(nslot, last_slot, nbit, w, fs_wide, fs_delay);
  assign fs_pre = fs_at(last_slot, last_slot, w - 1'b1, w, fs_wide, fs_delay);

  always_ff @(posedge clk) begin
    if (rst) begin
      hc_q    <= '0;
      phase_q <= 1'b0;
      run_q   <= 1'b0;
      bit_q   <= w - 1'b1;
      slot_q  <= last_slot;
      fs      <= fs_pre;
    end else begin
      hc_q <= wrap ? '0 : hc_q + 1'b1;
      if (wrap) phase_q <= ~phase_q;
      if (launch) begin
        bit_q  <= nbit;
        slot_q <= nslot;
        fs     <= fs_nx;
        run_q  <= 1'b1;
      end
    end
  end

  assign bclk           = phase_q;
  assign evt.launch     = launch;
  assign evt.slot_start = (nbit == '0);
  assign evt.act_next   = mask[nslot];
  assign evt.sample     = wrap & ~phase_q & run_q;
  assign evt.act_cur    = mask[slot_q];
  assign evt.last_bit   = bit_end;
  assign evt.width      = w;
endmodule

// File: rtl/tdm_pin_lane.sv
`timescale 1ns/1ps
module tdm_pin_lane (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        is_tx,
  input  tdm_pkg::zone_evt_t          tx_ev,
  input  tdm_pkg::zone_evt_t          rx_ev,
  input  logic                        sd_in,
  output logic                        sd_out,
  output logic                        sd_oe,
  input  logic [tdm_pkg::WMAX-1:0]    tx_data,
  input  logic                        tx_valid,
  output logic                        tx_ready,
  output logic [tdm_pkg::WMAX-1:0]    rx_data,
  output logic                        rx_valid,
  input  logic                        rx_ready,
  output logic                        underrun,
  output logic                        overrun
);
  import tdm_pkg::*;

  zone_evt_t        ev;
  logic [WMAX-1:0]  hold_q, tsh_q, rnext;
  logic [WMAX-2:0]  rsh_q;
  logic             full_q;

  assign ev       = is_tx ? tx_ev : rx_ev;
  assign tx_ready = is_tx & ~full_q;
  assign rnext    = {rsh_q, sd_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      full_q   <= 1'b0;
      tsh_q    <= '0;
      sd_out   <= 1'b0;
      sd_oe    <= 1'b0;
      underrun <= 1'b0;
    end else if (is_tx) begin
      if (tx_valid && !full_q) begin
        hold_q <= tx_data;
        full_q <= 1'b1;
      end
      if (ev.launch) begin
        if (!ev.act_next) begin
          tsh_q  <= tsh_q << 1;
          sd_out <= 1'b0;
          sd_oe  <= 1'b0;
        end else if (ev.slot_start) begin
          sd_oe <= 1'b1;
          if (full_q) begin
            tsh_q  <= hold_q;
            sd_out <= hold_q[WMAX-1];
            full_q <= 1'b0;
          end else begin
            tsh_q    <= '0;
            sd_out   <= 1'b0;
            underrun <= 1'b1;
          end
        end else begin
          tsh_q  <= tsh_q << 1;
          sd_out <= tsh_q[WMAX-2];
          sd_oe  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsh_q    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (!is_tx && ev.sample && ev.act_cur) begin
        rsh_q <= rnext[WMAX-2:0];
        if (ev.last_bit) begin
          rx_data  <= rnext << (WBITS'(WMAX) - ev.width);
          rx_valid <= 1'b1;
          if (rx_valid && !rx_ready) overrun <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_serial_port.sv
`timescale 1ns/1ps
module tdm_serial_port #(
  parameter int NPINS = 8,
  parameter int DIVW  = 7,
  parameter int SLOTW = 5,
  parameter int NSLOT = 1 << SLOTW,
  parameter int WMAX  = tdm_pkg::WMAX
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPINS-1:0]      pin_is_tx,
  input  logic [DIVW-1:0]       tx_div,
  input  logic [SLOTW-1:0]      tx_slots_m1,
  input  logic [2:0]            tx_wcode,
  input  logic                  tx_fs_wide,
  input  logic                  tx_fs_delay,
  input  logic [NSLOT-1:0]      tx_mask,
  input  logic [DIVW-1:0]       rx_div,
  input  logic [SLOTW-1:0]      rx_slots_m1,
  input  logic [2:0]            rx_wcode,
  input  logic                  rx_fs_wide,
  input  logic                  rx_fs_delay,
  input  logic [NSLOT-1:0]      rx_mask,
  output logic                  tx_bclk,
  output logic                  tx_fs,
  output logic                  rx_bclk,
  output logic                  rx_fs,
  input  logic [NPINS-1:0]      sd_in,
  output logic [NPINS-1:0]      sd_out,
  output logic [NPINS-1:0]      sd_oe,
  input  logic [NPINS*WMAX-1:0] tx_data,
  input  logic [NPINS-1:0]      tx_valid,
  output logic [NPINS-1:0]      tx_ready,
  output logic [NPINS*WMAX-1:0] rx_data,
  output logic [NPINS-1:0]      rx_valid,
  input  logic [NPINS-1:0]      rx_ready,
  output logic [NPINS-1:0]      underrun,
  output logic [NPINS-1:0]      overrun
);
  tdm_pkg::zone_evt_t tx_ev, rx_ev;

  tdm_zone_timer #(.DIVW(DIVW), .SLOTW(SLOTW), .NSLOT(NSLOT)) u_tx_zone (
    .clk(clk), .rst(rst), .div(tx_div), .slots_m1(tx_slots_m1),
    .wcode(tx_wcode), .fs_wide(tx_fs_wide), .fs_delay(tx_fs_delay),
    .mask(tx_mask), .bclk(tx_bclk), .fs(tx_fs), .evt(tx_ev));

  tdm_zone_timer #(.DIVW(DIVW), .SLOTW(SLOTW), .NSLOT(NSLOT)) u_rx_zone (
    .clk(clk), .rst(rst), .div(rx_div), .slots_m1(rx_slots_m1),
    .wcode(rx_wcode), .fs_wide(rx_fs_wide), .fs_delay(rx_fs_delay),
    .mask(rx_mask), .bclk(rx_bclk), .fs(rx_fs), .evt(rx_ev));

  for (genvar p = 0; p < NPINS; p++) begin : g_lane
    tdm_pin_lane u_lane (
      .clk(clk), .rst(rst), .is_tx(pin_is_tx[p]),
      .tx_ev(tx_ev), .rx_ev(rx_ev),
      .sd_in(sd_in[p]), .sd_out(sd_out[p]), .sd_oe(sd_oe[p]),
      .tx_data(tx_data[p*WMAX +: WMAX]), .tx_valid(tx_valid[p]),
      .tx_ready(tx_ready[p]),
      .rx_data(rx_data[p*WMAX +: WMAX]), .rx_valid(rx_valid[p]),
      .rx_ready(rx_ready[p]),
      .underrun(underrun[p]), .overrun(overrun[p]));
  end
endmodule

// File: rtl/tdm_port_checks.sv
`timescale 1ns/1ps
module tdm_port_checks #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_bclk,
  input logic             tx_fs,
  input logic [NPINS-1:0] sd_oe,
  input logic [NPINS-1:0] rx_valid,
  input logic [NPINS-1:0] rx_ready,
  input logic [NPINS-1:0] underrun,
  input logic [NPINS-1:0] overrun
);
  a_r12_fs_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_fs) |-> $fell(tx_bclk));

  a_r12_oe_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_oe) |-> $fell(tx_bclk));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    a_r11_valid_held: assert property (@(posedge clk) disable iff (rst)
      rx_valid[i] && !rx_ready[i] |=> rx_valid[i]);
    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
      underrun[i] |=> underrun[i]);
    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
      overrun[i] |=> overrun[i]);
  end
endmodule

bind tdm_serial_port tdm_port_checks #(.NPINS(NPINS)) u_checks (
  .clk(clk), .rst(rst), .tx_bclk(tx_bclk), .tx_fs(tx_fs), .sd_oe(sd_oe),
  .rx_valid(rx_valid), .rx_ready(rx_ready),
  .underrun(underrun), .overrun(overrun));

// File: tb/tdm_serial_port_bench.sv
`timescale 1ns/1ps
module tdm_serial_port_bench;
  localparam int NP = 8;
  logic clk, rst;
  logic [NP-1:0] pin_is_tx, sd_in, sd_out, sd_oe, tx_valid, tx_ready;
  logic [NP-1:0] rx_valid, rx_ready, underrun, overrun;
  logic [6:0] div;
  logic [4:0] slm1;
  logic [2:0] wc;
  logic wide, dly;
  logic [31:0] msk;
  logic [NP*32-1:0] tx_data, rx_data;

  tdm_serial_port u_tdm_serial_port (
    .clk(clk), .rst(rst), .pin_is_tx(pin_is_tx),
    .tx_div(div), .tx_slots_m1(slm1), .tx_wcode(wc), .tx_fs_wide(wide),
    .tx_fs_delay(dly), .tx_mask(msk),
    .rx_div(div), .rx_slots_m1(slm1), .rx_wcode(wc), .rx_fs_wide(wide),
    .rx_fs_delay(dly), .rx_mask(msk),
    .tx_bclk(), .tx_fs(), .rx_bclk(), .rx_fs(),
    .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .underrun(underrun), .overrun(overrun));

  assign sd_in = {sd_out[3:0], 4'b0000};

  int n_chk = 0, n_fail = 0;
  int sent[4], rcv[4];
  bit fire[4];
  logic [31:0] last_rx[4];
  bit [3:0] feed_en, drain_en;
  bit cmp_en;
  int cur_w;
  longint cyc = 0, last_rise = -1, fs_rise = -1, oe_rise = -1;
  longint bclk_per = 0, fs_per = 0, fs_hi = 0, fs2oe = -1, oe_hi = 0;
  int bad_oe = 0, bad_edge = 0;
  bit armed, pb, pfs, prst;
  logic [NP-1:0] poe;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int p, input int n);
    return {8'(p * 16 + n), 8'(n * 3 + p + 1) ^ 8'hA5, 8'hC3 ^ 8'(n), 8'(n * 7 + 1)};
  endfunction

  initial begin
    clk = 0;
    forever #2.5 clk = ~clk;
  end

  // stimulus, capture and interval monitor, all at the falling master edge
  initial begin
    tx_valid = '0; tx_data = '0; rx_ready = '0;
    forever begin
      @(negedge clk);
      cyc++;
      for (int p = 0; p < 4; p++) begin
        if (rst) begin sent[p] = 0; rcv[p] = 0; fire[p] = 0; end
        else if (fire[p]) sent[p]++;
        tx_valid[p] = feed_en[p];
        tx_data[p*32 +: 32] = word_of(p, sent[p]);
        fire[p] = !rst && tx_valid[p] && tx_ready[p];
        rx_ready[4+p] = drain_en[p];
        if (!rst && rx_valid[4+p] && rx_ready[4+p]) begin
          last_rx[p] = rx_data[(4+p)*32 +: 32];
          if (cmp_en)
            chk(last_rx[p] == (word_of(p, rcv[p]) & (32'hFFFF_FFFF << (32 - cur_w))),
                "R6 R7 R8 looped word", last_rx[p],
                word_of(p, rcv[p]) & (32'hFFFF_FFFF << (32 - cur_w)));
          rcv[p]++;
        end
      end
      if (rst) begin
        last_rise = -1; fs_rise = -1; armed = 0;
      end else begin
        if (u_tdm_serial_port.tx_bclk && !pb) begin
          if (last_rise >= 0) bclk_per = cyc - last_rise;
          last_rise = cyc;
        end
        if (u_tdm_serial_port.tx_fs && !pfs) begin
          if (fs_rise >= 0) fs_per = cyc - fs_rise;
          fs_rise = cyc; armed = 1;
        end
        if (!u_tdm_serial_port.tx_fs && pfs) fs_hi = cyc - fs_rise;
        if (sd_oe[0] && !poe[0]) begin
          if (armed) fs2oe = cyc - fs_rise;
          armed = 0; oe_rise = cyc;
        end
        if (!sd_oe[0] && poe[0]) oe_hi = cyc - oe_rise;
        if (|sd_oe[7:4]) bad_oe++;
        if (!prst && (u_tdm_serial_port.tx_fs != pfs || sd_oe != poe)
            && !(pb && !u_tdm_serial_port.tx_bclk)) bad_edge++;
      end
      pb = u_tdm_serial_port.tx_bclk; pfs = u_tdm_serial_port.tx_fs;
      poe = sd_oe; prst = rst;
    end
  end

  task automatic run_cfg(input int dv, input int sl, input int wcd, input bit wd,
                         input bit dl, input logic [31:0] m,
                         input longint exp_fs2oe, input longint exp_oe_hi);
    int r, w, s, f;
    rst = 1;
    div = 7'(dv); slm1 = 5'(sl); wc = 3'(wcd); wide = wd; dly = dl; msk = m;
    r = 2 * (dv + 1);
    w = (wcd == 7) ? 32 : 8 + 4 * wcd;
    s = (sl == 0) ? 2 : sl + 1;
    f = s * w * r;
    cur_w = w; feed_en = 4'hF; drain_en = 4'hF; cmp_en = 1; fs2oe = -1;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    repeat (3 * f + 4 * r + 20) @(negedge clk);
    chk(bclk_per == r, "R1 bit clock period", bclk_per, r);
    chk(fs_per == f, "R2 R3 frame period", fs_per, f);
    chk(fs_hi == (wd ? w * r : r), "R4 frame sync width", fs_hi, wd ? w * r : r);
    for (int k = 0; k < 4; k++)
      chk(rcv[k] >= 2, "R6 words looped back", rcv[k], 2);
    chk(underrun == 0 && overrun == 0, "R9 R10 no loss while fed", {underrun, overrun}, 0);
    if (exp_fs2oe >= 0) chk(fs2oe == exp_fs2oe, "R5 sync to data offset", fs2oe, exp_fs2oe);
    if (exp_oe_hi >= 0) chk(oe_hi == exp_oe_hi, "R8 enable length", oe_hi, exp_oe_hi);
  endtask

  initial begin
    rst = 1; pin_is_tx = 8'h0F; feed_en = 0; drain_en = 0; cmp_en = 0; cur_w = 32;
    div = 0; slm1 = 3; wc = 0; wide = 0; dly = 0; msk = '1;
    repeat (3) @(negedge clk);
    chk(sd_oe == 0 && rx_valid == 0 && underrun == 0 && overrun == 0 &&
        u_tdm_serial_port.tx_bclk == 0, "R1 R6 reset state",
        {sd_oe, rx_valid, underrun, overrun}, 0);
    run_cfg(1, 0, 7, 1, 1, 32'hFFFF_FFFF, -1, -1);
    run_cfg(2, 2, 3, 0, 1, 32'h0000_0003, 6, 240);
    run_cfg(0, 31, 6, 1, 0, 32'h8000_0001, -1, -1);
    run_cfg(127, 1, 0, 0, 0, 32'hFFFF_FFFF, -1, -1);
    run_cfg(0, 3, 0, 0, 0, 32'h0000_0005, 0, 16);
    // R9: starve pin 0 for two frames of the last setup (64 cycles each)
    cmp_en = 0; feed_en = 4'hE;
    repeat (140) @(negedge clk);
    chk(underrun[0] == 1, "R9 underrun flag set", underrun[0], 1);
    chk(underrun[1] == 0, "R9 fed pin clean", underrun[1], 0);
    chk(last_rx[0] == 0, "R9 zeros sent", last_rx[0], 0);
    // R10 R11: stop draining receive pin 5
    drain_en = 4'hD;
    repeat (140) @(negedge clk);
    chk(overrun[5] == 1, "R10 overrun flag set", overrun[5], 1);
    chk(overrun[4] == 0, "R10 drained pin clean", overrun[4], 0);
    chk(rx_valid[5] == 1, "R11 valid held", rx_valid[5], 1);
    chk(bad_oe == 0, "R6 receive pins never enabled", bad_oe, 0);
    chk(bad_edge == 0, "R12 changes only at bit clock fall", bad_edge, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule